// File: doc/BRIEF.md
# Test-Pattern Word Source with Preamble and Error Injection

This block drives the parallel data input of a serial link transmitter with one test word per clock. After a start pulse it can first emit a programmable lead-in word for a programmed number of cycles. It then emits the selected pattern:

- one of four pseudo-random bit sequences of different lengths;
- a slow square wave;
- a fast alternating pattern;
- or the user's own data, passed straight through.

A single pulse on the inject input corrupts exactly one bit of one word. A far-end checker can then show that it notices errors. A stop pulse returns the block to idle.

The pattern code, lead-in enable, lead-in word and lead-in length are captured on the start cycle. They hold until the next start, so the link settings may change while a test runs without disturbing it. Outputs are taken from registered state. In bypass mode the user data is forwarded through a multiplexer only, with no added latency.

Top module: `pattern_source`

## Requirements
- R1: While reset is high and in the cycle after it, and in every later idle cycle, `valid_o` is 0 and `data_o` is all zeros.
- R2: Pattern codes 0, 1, 2 and 3 select the pseudo-random sequences with feedback taps (7,6), (15,14), (23,18) and (31,28). Each is a left-shifting register of N bits, seeded with all ones on start. The new bit is s[N-1] xor s[T-1] and is shifted into bit 0. Output bit i of a word is the i-th new bit produced for that word, and every pattern cycle produces a fresh word of W new bits.
- R3: Code 4 gives a slow square wave: all-ones on the first pattern word, then all-zeros, alternating every word. Code 5 gives the fast pattern: every word has even-numbered bits 1 and odd-numbered bits 0.
- R4: When the lead-in is enabled and its length L is nonzero, the captured lead-in word appears with `valid_o` high for exactly L cycles starting the cycle after start. The pattern follows directly.
- R5: When the lead-in is disabled or L is 0, the first pattern word appears the cycle after start.
- R6: Codes 6 and 7 are bypass. During the pattern phase, `data_o` equals `user_data_i` in the same cycle.
- R7: A rising edge on `inject_i` seen in a pattern-phase cycle inverts bit 0 of the word in the next cycle only. No other bit or word changes.
- R8: A rising edge on `inject_i` in an idle or lead-in cycle has no effect on any word.
- R9: A stop pulse makes the next cycle idle from any state. Stop wins over a simultaneous start.
- R10: Settings are captured only on start. Changing them mid-run has no effect. A start while running restarts the lead-in and reseeds the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; captures settings |
| stop_i | input | 1 | Stop pulse; returns to idle |
| pat_sel_i | input | 3 | Pattern code (0-3 sequences, 4 slow, 5 fast, 6/7 bypass) |
| pre_en_i | input | 1 | Lead-in enable |
| pre_word_i | input | W | Lead-in word |
| pre_len_i | input | CW | Lead-in length in cycles |
| inject_i | input | 1 | Error-inject request, edge detected |
| user_data_i | input | W | Data forwarded in bypass mode |
| data_o | output | W | Output word |
| valid_o | output | 1 | High outside idle |

## Verification
Directed runs cover each pattern code from a clean start, with the lead-in off, with length 0 and with a short length. These separate wrong feedback taps, a wrong bit order and an off-by-one in the lead-in count. Injection is tried during the lead-in, during idle and during the pattern phase. This shows that only a pattern-phase edge flips a bit, and only for one word. A long random run then mixes start, stop, setting changes, user data and inject requests. It exposes capture-time bugs, stop/start priority and restart reseeding against a cycle-level model in the bench.

// File: rtl/pattern_source_pkg.sv
package pattern_source_pkg;

    typedef enum logic [2:0] {
        PAT_P7   = 3'd0,
        PAT_P15  = 3'd1,
        PAT_P23  = 3'd2,
        PAT_P31  = 3'd3,
        PAT_SLOW = 3'd4,
        PAT_FAST = 3'd5,
        PAT_BYP  = 3'd6,
        PAT_BYP2 = 3'd7
    } pat_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_RUN  = 2'd2
    } pgs_state_e;

    localparam int NUM_SEQ = 4;
    localparam int SEQ_LEN [NUM_SEQ] = '{7, 15, 23, 31};
    localparam int SEQ_TAP [NUM_SEQ] = '{6, 14, 18, 28};

    function automatic logic is_bypass(input pat_e p);
        return (p == PAT_BYP) || (p == PAT_BYP2);
    endfunction

endpackage

// File: rtl/pg_lfsr.sv
module pg_lfsr #(
    parameter int N   = 7,
    parameter int TAP = 6,
    parameter int W   = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_i,
    input  logic         adv_i,
    output logic [W-1:0] word_o
);
    logic [N-1:0] st_q;
    logic [N-1:0] st_adv;

    always_comb begin
        logic [N-1:0] s;
        logic         b;
        s = st_q;
        word_o = '0;
        for (int i = 0; i < W; i++) begin
            b = s[N-1] ^ s[TAP-1];
            word_o[i] = b;
            s = {s[N-2:0], b};
        end
        st_adv = s;
    end

    always_ff @(posedge clk) begin
        if (rst || seed_i) begin
            st_q <= '1;
        end else if (adv_i) begin
            st_q <= st_adv;
        end
    end
endmodule

// File: rtl/pg_tone.sv
module pg_tone #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_i,
    input  logic         adv_i,
    output logic [W-1:0] slow_o,
    output logic [W-1:0] fast_o
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst || seed_i) begin
            phase_q <= 1'b0;
        end else if (adv_i) begin
            phase_q <= ~phase_q;
        end
    end

    assign slow_o = phase_q ? '0 : '1;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            fast_o[i] = ((i % 2) == 0);
        end
    end
endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
    import pattern_source_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          pre_en_i,
    input  logic [CW-1:0] pre_len_i,
    output pgs_state_e    state_o,
    output logic          seed_o,
    output logic          adv_o
);
    pgs_state_e    st_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || stop_i) begin
            st_q   <= ST_IDLE;
            left_q <= '0;
        end else if (start_i) begin
            st_q   <= (pre_en_i && (pre_len_i != '0)) ? ST_LEAD : ST_RUN;
            left_q <= pre_len_i;
        end else if (st_q == ST_LEAD) begin
            if (left_q <= CW'(1)) begin
                st_q <= ST_RUN;
            end else begin
                left_q <= left_q - CW'(1);
            end
        end
    end

    assign state_o = st_q;
    assign seed_o  = start_i && !stop_i;
    assign adv_o   = (st_q == ST_RUN);
endmodule

// File: rtl/pattern_source.sv
module pattern_source
    import pattern_source_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [2:0]    pat_sel_i,
    input  logic          pre_en_i,
    input  logic [W-1:0]  pre_word_i,
    input  logic [CW-1:0] pre_len_i,
    input  logic          inject_i,
    input  logic [W-1:0]  user_data_i,
    output logic [W-1:0]  data_o,
    output logic          valid_o
);
    pgs_state_e   st_q;
    logic         seed;
    logic         adv;
    pat_e         sel_q;
    logic [W-1:0] lead_q;
    logic         inj_q;
    logic         pend_q;
    logic [W-1:0] seq_w [NUM_SEQ];
    logic [W-1:0] slow_w;
    logic [W-1:0] fast_w;
    logic [W-1:0] body;

    pg_ctrl #(.CW(CW)) i_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .pre_en_i(pre_en_i), .pre_len_i(pre_len_i),
        .state_o(st_q), .seed_o(seed), .adv_o(adv)
    );

    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
        pg_lfsr #(.N(SEQ_LEN[g]), .TAP(SEQ_TAP[g]), .W(W)) i_lfsr (
            .clk(clk), .rst(rst), .seed_i(seed), .adv_i(adv),
            .word_o(seq_w[g])
        );
    end

    pg_tone #(.W(W)) i_tone (
        .clk(clk), .rst(rst), .seed_i(seed), .adv_i(adv),
        .slow_o(slow_w), .fast_o(fast_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= PAT_P7;
            lead_q <= '0;
        end else if (seed) begin
            sel_q  <= pat_e'(pat_sel_i);
            lead_q <= pre_word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inj_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            inj_q  <= inject_i;
            pend_q <= !start_i && !stop_i && (st_q == ST_RUN) && inject_i && !inj_q;
        end
    end

    always_comb begin
        case (sel_q)
            PAT_P7:   body = seq_w[0];
            PAT_P15:  body = seq_w[1];
            PAT_P23:  body = seq_w[2];
            PAT_P31:  body = seq_w[3];
            PAT_SLOW: body = slow_w;
            PAT_FAST: body = fast_w;
            default:  body = user_data_i;
        endcase
    end

    always_comb begin
        case (st_q)
            ST_LEAD: data_o = lead_q;
            ST_RUN:  data_o = body ^ {{(W-1){1'b0}}, pend_q};
            default: data_o = '0;
        endcase
    end

    assign valid_o = (st_q != ST_IDLE);
endmodule

// File: rtl/pattern_source_chk.sv
module pattern_source_chk
    import pattern_source_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         stop_i,
    input logic         valid_o,
    input logic [W-1:0] data_o,
    input logic [W-1:0] user_data_i,
    input pgs_state_e   st,
    input pat_e         sel,
    input logic         pend
);
    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (data_o == '0));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !valid_o);

    // R9
    start_run_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !stop_i) |=> valid_o);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !start_i) |=> !valid_o);

    // R4
    lead_next_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LEAD && !start_i && !stop_i) |=> (st == ST_LEAD || st == ST_RUN));

    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && is_bypass(sel) && !pend) |-> (data_o == user_data_i));

    // R7
    inject_once_chk: assert property (@(posedge clk) disable iff (rst)
        pend |=> !pend);
endmodule

bind pattern_source pattern_source_chk #(.W(W)) i_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .valid_o(valid_o), .data_o(data_o), .user_data_i(user_data_i),
    .st(st_q), .sel(sel_q), .pend(pend_q)
);

// File: tb/test_pattern_source.sv
`timescale 1ns/1ps
module test_pattern_source;
    localparam int W  = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0, stop_i = 1'b0, pre_en_i = 1'b0, inject_i = 1'b0;
    logic [2:0]    pat_sel_i = 3'd0;
    logic [W-1:0]  pre_word_i = '0, user_data_i = '0;
    logic [CW-1:0] pre_len_i = '0;
    logic [W-1:0]  data_o;
    logic          valid_o;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    pattern_source #(.W(W), .CW(CW)) i_pattern_source (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .pat_sel_i(pat_sel_i), .pre_en_i(pre_en_i), .pre_word_i(pre_word_i),
        .pre_len_i(pre_len_i), .inject_i(inject_i), .user_data_i(user_data_i),
        .data_o(data_o), .valid_o(valid_o)
    );

    // bench model of the requirements
    int            m_st = 0;        // 0 idle, 1 lead-in, 2 pattern
    int            m_left = 0;
    int            m_sel = 0;
    logic [W-1:0]  m_lead = '0;
    logic [30:0]   m_reg [4];
    logic          m_phase = 1'b0;
    logic          m_pend = 1'b0;
    logic          m_injq = 1'b0;

    function automatic int seq_n(input int k);
        case (k) 0: return 7; 1: return 15; 2: return 23; default: return 31; endcase
    endfunction
    function automatic int seq_t(input int k);
        case (k) 0: return 6; 1: return 14; 2: return 18; default: return 28; endcase
    endfunction

    function automatic logic [W-1:0] seq_word(input logic [30:0] s0, input int k,
                                              output logic [30:0] s_out);
        logic [30:0]  s;
        logic [W-1:0] w;
        logic         b;
        int n, t;
        n = seq_n(k); t = seq_t(k); s = s0; w = '0;
        for (int i = 0; i < W; i++) begin
            b = s[n-1] ^ s[t-1];
            w[i] = b;
            s = ((s << 1) | 31'(b)) & ((31'(1) << n) - 31'(1));
        end
        s_out = s;
        return w;
    endfunction

    function automatic logic [W-1:0] expect_word();
        logic [W-1:0] w;
        logic [30:0]  dummy;
        if (m_st == 0) return '0;
        if (m_st == 1) return m_lead;
        if (m_sel < 4) w = seq_word(m_reg[m_sel], m_sel, dummy);
        else if (m_sel == 4) w = m_phase ? '0 : '1;
        else if (m_sel == 5) w = {(W/2){2'b01}};
        else w = user_data_i;
        return w ^ {{(W-1){1'b0}}, m_pend};
    endfunction

    always @(posedge clk) begin
        logic rise;
        logic [30:0] ns;
        logic [W-1:0] junk;
        rise = inject_i && !m_injq;
        if (rst) begin
            m_st = 0; m_pend = 0; m_injq = 0;
        end else begin
            m_injq = inject_i;
            if (stop_i) begin
                m_st = 0; m_pend = 0;
            end else if (start_i) begin
                m_sel = int'(pat_sel_i); m_lead = pre_word_i;
                for (int k = 0; k < 4; k++) m_reg[k] = '1;
                m_phase = 0; m_pend = 0; m_left = int'(pre_len_i);
                m_st = (pre_en_i && pre_len_i != 0) ? 1 : 2;
            end else if (m_st == 1) begin
                m_pend = 0;
                if (m_left <= 1) m_st = 2; else m_left--;
            end else if (m_st == 2) begin
                for (int k = 0; k < 4; k++) begin
                    junk = seq_word(m_reg[k], k, ns);
                    m_reg[k] = ns;
                end
                m_phase = ~m_phase;
                m_pend = rise;
            end else begin
                m_pend = 0;
            end
        end
    end

    task automatic check_out();
        logic [W-1:0] ew;
        logic ev;
        ew = expect_word();
        ev = (m_st != 0);
        checks++;
        if (data_o !== ew || valid_o !== ev) begin
            errors++;
            $display("FAIL %s: data=%h valid=%b expected data=%h valid=%b",
                     cur_req, data_o, valid_o, ew, ev);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check_out();
    endtask

    task automatic clear_in();
        start_i = 0; stop_i = 0; inject_i = 0;
    endtask

    task automatic do_start(input int sel, input logic en, input int len);
        pat_sel_i = 3'(sel); pre_en_i = en; pre_len_i = CW'(len);
        pre_word_i = $urandom; start_i = 1;
        step(); clear_in();
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cur_req = "R1";
        step(); step();
        rst = 0;
        step(); step();
        // R2: every sequence from a clean start, no lead-in (R5)
        for (int k = 0; k < 4; k++) begin
            cur_req = "R2";
            do_start(k, 0, 0);
            for (int c = 0; c < 6; c++) step();
        end
        // R3: slow and fast patterns
        cur_req = "R3";
        do_start(4, 1, 0);
        for (int c = 0; c < 5; c++) step();
        do_start(5, 0, 3);
        for (int c = 0; c < 4; c++) step();
        // R4: lead-in of 3 and of 1, with inject during lead-in (R8)
        cur_req = "R4";
        pat_sel_i = 3'd0; pre_en_i = 1; pre_len_i = 3; pre_word_i = 32'hA5C3_0FF1;
        start_i = 1; step(); clear_in();
        cur_req = "R8";
        inject_i = 1; step(); inject_i = 0; step(); step();
        for (int c = 0; c < 3; c++) step();
        cur_req = "R4";
        do_start(1, 1, 1);
        for (int c = 0; c < 3; c++) step();
        // R6: bypass
        cur_req = "R6";
        do_start(6, 0, 0);
        for (int c = 0; c < 4; c++) begin user_data_i = $urandom; step(); end
        do_start(7, 0, 0);
        user_data_i = 32'hDEAD_BEEF; step();
        // R7: inject in pattern phase, held high for several cycles
        cur_req = "R7";
        do_start(3, 0, 0);
        inject_i = 1; step(); step(); step(); inject_i = 0; step(); step();
        // R9: stop, and stop together with start
        cur_req = "R9";
        stop_i = 1; step(); clear_in(); step();
        start_i = 1; stop_i = 1; step(); clear_in(); step();
        // R8: inject while idle
        cur_req = "R8";
        inject_i = 1; step(); inject_i = 0; step();
        do_start(0, 0, 0); step(); step();
        // R10: settings changed mid-run, then restart
        cur_req = "R10";
        do_start(2, 0, 0);
        pat_sel_i = 3'd5; pre_word_i = '1; pre_en_i = 1; pre_len_i = 2;
        step(); step(); step();
        start_i = 1; step(); clear_in();
        for (int c = 0; c < 5; c++) step();
        // random mix
        cur_req = "R10 random";
        for (int c = 0; c < 4000; c++) begin
            start_i     = ($urandom_range(0, 29) == 0);
            stop_i      = ($urandom_range(0, 79) == 0);
            inject_i    = ($urandom_range(0, 5) == 0);
            pat_sel_i   = 3'($urandom_range(0, 7));
            pre_en_i    = 1'($urandom_range(0, 1));
            pre_len_i   = CW'($urandom_range(0, 6));
            pre_word_i  = $urandom;
            user_data_i = $urandom;
            step();
        end
        clear_in();
        step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule